// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block connects a simple host request port to a 256K x 16 EDO DRAM that takes its address in two halves on a 9-bit bus. The host presents an 18-bit word address, a read/write flag, two byte enables and 16 bits of write data. It holds `req_valid_i` high until `req_done_o` pulses. The controller splits the address into a row half and a column half. It strobes the row with the row-address strobe and the column with one or both column strobes. The low strobe carries the low byte and the high strobe carries the high byte, so a single byte or the whole word moves in one access.

After an access the row stays open. A later request to the same row is served with only a new column and a column-strobe pulse. A request to another row first closes the row and waits out the precharge. A free-running interval timer raises a refresh request about every 15.6 us, rounded down to whole clocks, which gives 512 refreshes in 8 ms. The refresh runs with both column strobes falling before the row strobe, so no refresh address is needed. Every minimum timing is given in nanoseconds and is turned into a clock count by ceiling division with the clock-period parameter.

The host must present a new request, or drop `req_valid_i`, in the cycle where it sees `req_done_o`.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `casl_n_o`, `cash_n_o`, `we_n_o` and `oe_n_o` are high, and `dq_oe_o` and `req_done_o` are low.
- R2: The row is `req_addr_i[17:9]`, driven on `addr_o` when `ras_n_o` falls. The column is `req_addr_i[8:0]`, driven on `addr_o` when a column strobe falls.
- R3: `req_be_i[0]` selects `casl_n_o`, which moves bits 7:0. `req_be_i[1]` selects `cash_n_o`, which moves bits 15:8. A byte write leaves the other byte of the stored word unchanged.
- R4: A read returns the stored bytes on `req_rdata_o` in the cycle that `req_done_o` is high. The bytes that were not enabled are don't-care.
- R5: A request to the row that is already open causes no new fall of `ras_n_o`.
- R6: A request to a different row raises `ras_n_o` only after it has been low for at least C_RAS = C_RC - C_RP clocks. The next row activation follows only after at least C_RP clocks of precharge.
- R7: The access timings hold in clocks:
  - `ras_n_o` fall to column-strobe fall is at least C_RAC - C_CAC.
  - Column strobe low is at least C_CAC.
  - Column-strobe fall to fall is at least C_PC.
  - `ras_n_o` fall to fall is at least C_RC.
  - Both column strobes are high when `ras_n_o` falls for an access.
- R8: Writes are early writes. `we_n_o` is low and `dq_oe_o` is high with the data on `dq_o` at least one clock before the column strobe falls. `dq_oe_o` is high only while `we_n_o` is low.
- R9: `oe_n_o` is low during read column pulses and is never low while `we_n_o` is low.
- R10: A refresh drives both column strobes low at least C_CSR clocks before `ras_n_o` falls. Refreshes come every C_REF = floor(REF_INTERVAL_NS / CLK_PERIOD_NS) clocks, give or take the latency of one access.
- R11: A pending refresh wins over a waiting host request. An open row is closed before the refresh begins, so the first access after a refresh activates its row again.
- R12: `req_done_o` is a single-cycle pulse at the end of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address, row in the upper half |
| req_be_i | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata_i | input | 16 | Write data |
| req_done_o | output | 1 | Access complete, one-cycle pulse |
| req_rdata_o | output | 16 | Read data, valid with done |
| ras_n_o | output | 1 | Row address strobe, active low |
| casl_n_o | output | 1 | Low-byte column strobe, active low |
| cash_n_o | output | 1 | High-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| addr_o | output | 9 | Multiplexed row/column address |
| dq_o | output | 16 | Data driven to the DRAM |
| dq_oe_o | output | 1 | Drive enable for `dq_o` |
| dq_i | input | 16 | Data returned from the DRAM |

## Verification
A refresh request can become pending in the same cycle that a host request waits at an open page. The design must then give up the page hit, close the row and refresh first. The bench provokes this with an unbroken stream of same-row reads across two refresh intervals. It judges the outcome by three things: every refresh lands within a bounded window of its due time, every read still returns the stored word, and the behavioural DRAM sees a closed row and correct strobe ordering at each refresh. A separate check confirms that the first access after a refresh activates its row again.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACT,
    S_COL,
    S_CAS,
    S_OPEN,
    S_PRE,
    S_RCAS,
    S_RRAS,
    S_RPRE
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/edo_delay_cnt.sv
`timescale 1ns/1ps
module edo_delay_cnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/edo_refresh_timer.sv
`timescale 1ns/1ps
module edo_refresh_timer #(
  parameter int PERIOD = 3120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic pend_o
);
  localparam int W = $clog2(PERIOD + 1);

  logic [W-1:0] cnt_q;
  logic         pend_q;
  logic         tick;

  assign tick = (cnt_q == W'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)        pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // refresh is only started against a pending request
  assert_take_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q);
endmodule

// File: rtl/edo_row_tracker.sv
`timescale 1ns/1ps
module edo_row_tracker #(
  parameter int RW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [RW-1:0] row_i,
  output logic          hit_o
);
  logic [RW-1:0] row_q;
  logic          open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      open_q <= 1'b0;
    end else if (set_i) begin
      row_q  <= row_i;
      open_q <= 1'b1;
    end else if (clr_i) begin
      open_q <= 1'b0;
    end
  end

  assign hit_o = open_q && (row_q == row_i);
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_PERIOD_NS   = 5,
  parameter int T_RC_NS         = 65,
  parameter int T_RAC_NS        = 35,
  parameter int T_CAC_NS        = 10,
  parameter int T_PC_NS         = 14,
  parameter int T_RP_NS         = 25,
  parameter int T_CSR_NS        = 10,
  parameter int REF_INTERVAL_NS = 15600,
  parameter int AW              = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [1:0]      req_be_i,
  input  logic [15:0]     req_wdata_i,
  output logic            req_done_o,
  output logic [15:0]     req_rdata_o,
  output logic            ras_n_o,
  output logic            casl_n_o,
  output logic            cash_n_o,
  output logic            we_n_o,
  output logic            oe_n_o,
  output logic [AW/2-1:0] addr_o,
  output logic [15:0]     dq_o,
  output logic            dq_oe_o,
  input  logic [15:0]     dq_i
);
  localparam int PAW   = AW / 2;
  localparam int C_RC  = ceil_div(T_RC_NS, CLK_PERIOD_NS);
  localparam int C_RAC = ceil_div(T_RAC_NS, CLK_PERIOD_NS);
  localparam int C_CAC = ceil_div(T_CAC_NS, CLK_PERIOD_NS);
  localparam int C_PC  = ceil_div(T_PC_NS, CLK_PERIOD_NS);
  localparam int C_RP  = ceil_div(T_RP_NS, CLK_PERIOD_NS);
  localparam int C_CSR = ceil_div(T_CSR_NS, CLK_PERIOD_NS);
  localparam int C_RAS = (C_RC > C_RP + 1) ? C_RC - C_RP : 1;
  localparam int C_RCD = (C_RAC > C_CAC + 2) ? C_RAC - C_CAC : 2;
  localparam int C_REF = REF_INTERVAL_NS / CLK_PERIOD_NS;
  localparam int PC_LD = (C_PC > 2) ? C_PC - 2 : 0;
  localparam int CW    = $clog2(C_RC + C_RAC + C_CSR + C_PC + 2) + 1;

  ctrl_state_e state_q, state_d;

  logic            ras_q, ras_d, cl_q, cl_d, ch_q, ch_d;
  logic            we_q, we_d, oe_q, oe_d, dqoe_q, dqoe_d;
  logic [PAW-1:0]  addr_q, addr_d;
  logic [15:0]     dq_q, dq_d, rdata_q;
  logic            done_q, done_d, cap;
  logic            wait_ld, wait_zero, ras_ok, pc_ok;
  logic [CW-1:0]   wait_val;
  logic            ras_start, cas_start, row_set, row_clr, ref_take;
  logic            ref_pend, row_hit;
  logic [PAW-1:0]  req_row, req_col;

  assign req_row = req_addr_i[AW-1:PAW];
  assign req_col = req_addr_i[PAW-1:0];

  edo_delay_cnt #(.W(CW)) u_wait (
    .clk_i, .rst_ni, .load_i(wait_ld), .val_i(wait_val), .zero_o(wait_zero)
  );

  // minimum row-active time
  edo_delay_cnt #(.W(CW)) u_ras_age (
    .clk_i, .rst_ni, .load_i(ras_start), .val_i(CW'(C_RAS - 1)), .zero_o(ras_ok)
  );

  // column-strobe fall-to-fall spacing
  edo_delay_cnt #(.W(CW)) u_page (
    .clk_i, .rst_ni, .load_i(cas_start), .val_i(CW'(PC_LD)), .zero_o(pc_ok)
  );

  edo_refresh_timer #(.PERIOD(C_REF)) u_ref (
    .clk_i, .rst_ni, .take_i(ref_take), .pend_o(ref_pend)
  );

  edo_row_tracker #(.RW(PAW)) u_row (
    .clk_i, .rst_ni, .set_i(row_set), .clr_i(row_clr), .row_i(req_row), .hit_o(row_hit)
  );

  always_comb begin
    state_d   = state_q;
    ras_d     = ras_q;
    cl_d      = cl_q;
    ch_d      = ch_q;
    we_d      = we_q;
    oe_d      = oe_q;
    dqoe_d    = dqoe_q;
    addr_d    = addr_q;
    dq_d      = dq_q;
    done_d    = 1'b0;
    cap       = 1'b0;
    wait_ld   = 1'b0;
    wait_val  = '0;
    ras_start = 1'b0;
    cas_start = 1'b0;
    row_set   = 1'b0;
    row_clr   = 1'b0;
    ref_take  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_pend) begin
          state_d  = S_RCAS;
          cl_d     = 1'b0;
          ch_d     = 1'b0;
          ref_take = 1'b1;
          wait_ld  = 1'b1;
          wait_val = CW'(C_CSR - 1);
        end else if (req_valid_i) begin
          state_d   = S_ACT;
          ras_d     = 1'b0;
          addr_d    = req_row;
          ras_start = 1'b1;
          row_set   = 1'b1;
          wait_ld   = 1'b1;
          wait_val  = CW'(C_RCD - 2);
        end
      end
      S_ACT: begin
        if (wait_zero) begin
          state_d = S_COL;
          addr_d  = req_col;
          we_d    = !req_we_i;
          dq_d    = req_wdata_i;
          dqoe_d  = req_we_i;
        end
      end
      S_COL: begin
        state_d   = S_CAS;
        cl_d      = !req_be_i[0];
        ch_d      = !req_be_i[1];
        oe_d      = req_we_i;
        cas_start = 1'b1;
        wait_ld   = 1'b1;
        wait_val  = CW'(C_CAC - 1);
      end
      S_CAS: begin
        if (wait_zero) begin
          state_d = S_OPEN;
          cl_d    = 1'b1;
          ch_d    = 1'b1;
          oe_d    = 1'b1;
          we_d    = 1'b1;
          dqoe_d  = 1'b0;
          done_d  = 1'b1;
          cap     = we_q;
        end
      end
      S_OPEN: begin
        if (ref_pend || (req_valid_i && !row_hit)) begin
          if (ras_ok) begin
            state_d  = S_PRE;
            ras_d    = 1'b1;
            row_clr  = 1'b1;
            wait_ld  = 1'b1;
            wait_val = CW'(C_RP - 1);
          end
        end else if (req_valid_i && pc_ok) begin
          state_d = S_COL;
          addr_d  = req_col;
          we_d    = !req_we_i;
          dq_d    = req_wdata_i;
          dqoe_d  = req_we_i;
        end
      end
      S_PRE: if (wait_zero) state_d = S_IDLE;
      S_RCAS: begin
        if (wait_zero) begin
          state_d   = S_RRAS;
          ras_d     = 1'b0;
          ras_start = 1'b1;
          wait_ld   = 1'b1;
          wait_val  = CW'(C_RAS - 1);
        end
      end
      S_RRAS: begin
        if (wait_zero) begin
          state_d  = S_RPRE;
          ras_d    = 1'b1;
          cl_d     = 1'b1;
          ch_d     = 1'b1;
          wait_ld  = 1'b1;
          wait_val = CW'(C_RP - 1);
        end
      end
      S_RPRE: if (wait_zero) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ras_q   <= 1'b1;
      cl_q    <= 1'b1;
      ch_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      dqoe_q  <= 1'b0;
      addr_q  <= '0;
      dq_q    <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      ras_q   <= ras_d;
      cl_q    <= cl_d;
      ch_q    <= ch_d;
      we_q    <= we_d;
      oe_q    <= oe_d;
      dqoe_q  <= dqoe_d;
      addr_q  <= addr_d;
      dq_q    <= dq_d;
      done_q  <= done_d;
      if (cap) rdata_q <= dq_i;
    end
  end

  assign ras_n_o     = ras_q;
  assign casl_n_o    = cl_q;
  assign cash_n_o    = ch_q;
  assign we_n_o      = we_q;
  assign oe_n_o      = oe_q;
  assign dq_oe_o     = dqoe_q;
  assign addr_o      = addr_q;
  assign dq_o        = dq_q;
  assign req_done_o  = done_q;
  assign req_rdata_o = rdata_q;

  assert_ras_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> $past(ras_ok));

  assert_bus_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !we_n_o);

  assert_oe_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> we_n_o);

  // a strobe low at row fall means refresh, and then both are low
  assert_cbr_pair_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !casl_n_o) |-> !cash_n_o);

  assert_ref_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && casl_n_o && cash_n_o) |-> !$past(ref_pend));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);
endmodule

// File: tb/edo_dram_ctrl_tb.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb;
  localparam int C_RC  = 13;
  localparam int C_RAC = 7;
  localparam int C_CAC = 2;
  localparam int C_PC  = 3;
  localparam int C_RP  = 5;
  localparam int C_CSR = 2;
  localparam int C_RAS = C_RC - C_RP;
  localparam int C_RCD = C_RAC - C_CAC;
  localparam int C_REF = 3120;
  localparam int SLACK = 40;

  typedef struct packed {
    logic        we;
    logic [17:0] addr;
    logic [1:0]  be;
    logic [15:0] wdata;
    logic [15:0] exp;
    logic        act;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 18'h00200, 2'b11, 16'hA5C3, 16'h0000, 1'b1},
    '{1'b1, 18'h00201, 2'b11, 16'h1234, 16'h0000, 1'b0},
    '{1'b0, 18'h00200, 2'b11, 16'h0000, 16'hA5C3, 1'b0},
    '{1'b1, 18'h00201, 2'b01, 16'h00FF, 16'h0000, 1'b0},
    '{1'b0, 18'h00201, 2'b11, 16'h0000, 16'h12FF, 1'b0},
    '{1'b1, 18'h00201, 2'b10, 16'h9900, 16'h0000, 1'b0},
    '{1'b0, 18'h00201, 2'b11, 16'h0000, 16'h99FF, 1'b0},
    '{1'b1, 18'h3FFFF, 2'b11, 16'hBEEF, 16'h0000, 1'b1},
    '{1'b0, 18'h00200, 2'b11, 16'h0000, 16'hA5C3, 1'b1},
    '{1'b0, 18'h3FFFF, 2'b10, 16'h0000, 16'hBE00, 1'b1},
    '{1'b0, 18'h3FFFF, 2'b01, 16'h0000, 16'h00EF, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [17:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        req_done;
  logic [15:0] req_rdata;
  logic        ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
  logic [8:0]  addr;
  logic [15:0] dq_o;
  logic [15:0] dq_drv;

  always #2.5 clk = ~clk;

  edo_dram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_wdata_i(req_wdata),
    .req_done_o(req_done), .req_rdata_o(req_rdata),
    .ras_n_o(ras_n), .casl_n_o(casl_n), .cash_n_o(cash_n),
    .we_n_o(we_n), .oe_n_o(oe_n), .addr_o(addr),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_drv)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural DRAM with timing checks
  int cyc = 0;
  int t_rst = 0, t_ras_fall = -1000, t_ras_rise = -1000, t_cas_fall = -1000;
  int t_cbr = 0, t_we_fall = -1000, t_ref = 0;
  int ref_cnt = 0, act_cnt = 0;
  bit p_ras = 1, p_cl = 1, p_ch = 1, p_we = 1, rd_pulse = 0;
  logic [8:0]  m_row = '0, m_col = '0;
  logic [15:0] mem [int];

  always @(posedge clk) begin
    int key;
    logic [15:0] word;
    cyc++;
    if (!rst_n) begin
      t_rst = cyc;
      p_ras = 1; p_cl = 1; p_ch = 1; p_we = 1;
      dq_drv <= '0;
    end else begin
      if (p_we && !we_n) t_we_fall = cyc;
      if (p_ras && !ras_n) begin
        if (!casl_n && !cash_n) begin
          check(cyc - t_cbr >= C_CSR, "R10 strobe lead before row fall", 32'(cyc - t_cbr), 32'(C_CSR));
          if (ref_cnt == 0)
            check(cyc - t_rst <= C_REF + SLACK, "R10 first refresh late", 32'(cyc - t_rst), 32'(C_REF));
          else
            check((cyc - t_ref >= C_REF - SLACK) && (cyc - t_ref <= C_REF + SLACK),
                  "R10 R11 refresh spacing", 32'(cyc - t_ref), 32'(C_REF));
          t_ref = cyc;
          ref_cnt++;
        end else begin
          check(casl_n && cash_n, "R7 strobes high at row fall", {casl_n, cash_n}, 2'b11);
          check(cyc - t_ras_rise >= C_RP, "R6 precharge", 32'(cyc - t_ras_rise), 32'(C_RP));
          check(cyc - t_ras_fall >= C_RC, "R7 row cycle", 32'(cyc - t_ras_fall), 32'(C_RC));
          m_row = addr;
          act_cnt++;
        end
        t_ras_fall = cyc;
      end
      if (!p_ras && ras_n) begin
        check(cyc - t_ras_fall >= C_RAS, "R6 row active time", 32'(cyc - t_ras_fall), 32'(C_RAS));
        t_ras_rise = cyc;
      end
      if ((p_cl && !casl_n) || (p_ch && !cash_n)) begin
        if (ras_n) t_cbr = cyc;
        else begin
          check(cyc - t_ras_fall >= C_RCD, "R7 row to column", 32'(cyc - t_ras_fall), 32'(C_RCD));
          check(cyc - t_cas_fall >= C_PC, "R7 page cycle", 32'(cyc - t_cas_fall), 32'(C_PC));
          t_cas_fall = cyc;
          m_col = addr;
          key = int'({m_row, m_col});
          word = mem.exists(key) ? mem[key] : 16'h0000;
          if (!we_n) begin
            check(dq_oe && (t_we_fall < cyc), "R8 early write setup", {31'd0, dq_oe}, 1);
            if (!casl_n) word[7:0]  = dq_o[7:0];
            if (!cash_n) word[15:8] = dq_o[15:8];
            mem[key] = word;
            rd_pulse = 0;
          end else begin
            check(!oe_n && !dq_oe, "R9 output enable on read", {oe_n, dq_oe}, 0);
            if (!casl_n) dq_drv[7:0]  <= word[7:0];
            if (!cash_n) dq_drv[15:8] <= word[15:8];
            rd_pulse = 1;
          end
        end
      end
      if (!ras_n && rd_pulse && casl_n && cash_n && !(p_cl && p_ch)) begin
        check(cyc - t_cas_fall >= C_CAC, "R7 column access", 32'(cyc - t_cas_fall), 32'(C_CAC));
        rd_pulse = 0;
      end
      p_ras = ras_n; p_cl = casl_n; p_ch = cash_n; p_we = we_n;
    end
  end

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // caller sits at a negedge; returns at the negedge where done is seen
  task automatic do_req(input logic we, input logic [17:0] a, input logic [1:0] be, input logic [15:0] wd);
    int dones;
    req_valid = 1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    do @(negedge clk); while (!req_done);
    req_valid = 0;
    @(negedge clk);
    dones = int'(req_done);
    check(dones == 0, "R12 done single pulse", 32'(dones), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int a0;
    logic [15:0] mask;
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    check({ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, req_done} == 7'b1111100,
          "R1 reset outputs", {ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, req_done}, 7'b1111100);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      a0 = act_cnt;
      do_req(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wdata);
      check({m_row, m_col} == VEC[i].addr, "R2 row/column split", {m_row, m_col}, VEC[i].addr);
      check(act_cnt - a0 == int'(VEC[i].act), VEC[i].act ? "R6 row miss activates" : "R5 page hit no activate",
            32'(act_cnt - a0), {31'd0, VEC[i].act});
      if (!VEC[i].we) begin
        mask = {{8{VEC[i].be[1]}}, {8{VEC[i].be[0]}}};
        check((req_rdata & mask) == VEC[i].exp, "R3 R4 read data", req_rdata & mask, VEC[i].exp);
      end
    end

    // stream page hits across refreshes
    while (cyc < 2 * C_REF + 200) begin
      do_req(1'b0, 18'h00200, 2'b11, 16'h0);
      if (req_rdata != 16'hA5C3)
        check(0, "R11 read during refresh stream", req_rdata, 16'hA5C3);
    end
    check(ref_cnt == 2, "R11 refresh not starved", 32'(ref_cnt), 2);
    check(req_rdata == 16'hA5C3, "R11 data intact", req_rdata, 16'hA5C3);

    // idle refresh rate
    while (cyc < 4 * C_REF + 100) @(negedge clk);
    check(ref_cnt == 4, "R10 refresh count", 32'(ref_cnt), 4);

    // first access after refresh reopens its row
    a0 = act_cnt;
    do_req(1'b0, 18'h3FFFF, 2'b11, 16'h0);
    check(act_cnt - a0 == 1, "R11 row closed by refresh", 32'(act_cnt - a0), 1);
    check(req_rdata == 16'hBEEF, "R4 word read", req_rdata, 16'hBEEF);

    report();
  end
endmodule